// File: doc/BRIEF.md
# Audio Controller Immediate Command Register Block

This block lets software talk to an attached audio codec one command at a time, through a few memory-mapped registers and no command or response rings in memory. Software loads a 32-bit verb into a command register. Bits 31:28 of that verb select the target codec. Software then launches the verb by writing both low status bits as ones. The block offers the verb to the codec over a request/acknowledge handshake and waits for the codec's response strobe. It captures the 32-bit response dword and reports completion as busy cleared and response-valid set.

The same register map holds a global control register with a run bit. Writing 1 to the run bit brings the controller out of reset. Writing 0 halts the controller and clears the command path. The map also shows a codec-presence field with one bit per codec address. Accesses are dword-wide. Address bits [1:0] are ignored, and reads are combinational from the read address.

Top module: `aud_imm_cmd`

## Requirements
- R1: After rst_n is deasserted, every register reads 0 and cdc_req is 0.
- R2: Reads decode dword offsets: 08h is global control, 0Ch carries presence, 60h is the command, 64h is the response and 68h is the status. Any other offset reads 0.
- R3: Bit 0 of offset 08h is the run bit and reads back the last value written to it. While it reads 0, the command, response and status registers read 0, cdc_req stays 0, and writes to 60h and 68h have no effect.
- R4: Presence bit k (k below N_CODEC) sits at bit 16+k of the dword at 0Ch, which is byte 0Eh bit k. It shows codec_present[k] as sampled one clock earlier, and it reads 0 while the run bit is 0.
- R5: Status bit 0 is busy and bit 1 is response-valid. While the block is idle, writing 11b to status bits [1:0] launches the verb: from the next cycle busy reads 1, response-valid reads 0, cdc_req is 1 and cdc_verb equals the command register. Writing 01b or 10b does not launch.
- R6: Once raised, cdc_req stays at 1 with cdc_verb unchanged until a cycle in which cdc_ack is 1. It drops in the cycle after that.
- R7: After the acknowledge, the first cycle with cdc_rsp_vld at 1 captures cdc_rsp_data into the response register at 64h. From the next cycle the status reads 10b. A cdc_rsp_vld before or in the acknowledge cycle is ignored.
- R8: While idle, writing 1 to status bit 1 clears response-valid. The response register is unchanged.
- R9: While busy, writes to 60h and 68h are ignored.
- R10: Writing 0 to the run bit aborts at that same edge. From the next cycle the command, response and status registers read 0 and cdc_req is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_waddr | input | 8 | Write byte address |
| reg_wdata | input | 32 | Write data |
| reg_raddr | input | 8 | Read byte address |
| reg_rdata | output | 32 | Read data (combinational) |
| codec_present | input | N_CODEC | One presence flag per codec address |
| cdc_req | output | 1 | Verb offered to the codec |
| cdc_verb | output | 32 | Verb being offered |
| cdc_ack | input | 1 | Codec accepted the verb |
| cdc_rsp_vld | input | 1 | Codec response strobe |
| cdc_rsp_data | input | 32 | Codec response dword |

## Verification
A wrong phase in the command path shows up in the same read cycle as a status code other than the expected 00b, 01b or 10b, or as a cdc_req level that does not match the handshake history. The bench compares every port and one rotating register read against a behavioural model on every clock, so such an error is reported within one cycle. A response or command corrupted by an ignored write or a stray strobe becomes visible within six cycles, because the read address rotation covers every offset in that span.

// File: rtl/aud_imm_pkg.sv
package aud_imm_pkg;

    localparam int REG_AW   = 8;
    localparam int REG_DW   = 32;
    localparam int PRES_LSB = 16;

    localparam logic [REG_AW-1:0] OFS_GCTL = 8'h08;
    localparam logic [REG_AW-1:0] OFS_PRES = 8'h0C;
    localparam logic [REG_AW-1:0] OFS_CMD  = 8'h60;
    localparam logic [REG_AW-1:0] OFS_RSP  = 8'h64;
    localparam logic [REG_AW-1:0] OFS_STS  = 8'h68;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_REQ  = 2'd1,
        PH_WAIT = 2'd2
    } phase_e;

    typedef struct packed {
        logic [REG_DW-1:0] cmd;
        logic [REG_DW-1:0] resp;
        logic              valid;
        phase_e            phase;
    } cmd_st_t;

    function automatic logic dw_hit(input logic [REG_AW-1:0] a, input logic [REG_AW-1:0] ofs);
        return a[REG_AW-1:2] == ofs[REG_AW-1:2];
    endfunction

endpackage

// File: rtl/aud_imm_gctl.sv
module aud_imm_gctl #(
    parameter int N_CODEC = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_run,
    input  logic               wr_run_val,
    input  logic [N_CODEC-1:0] codec_present,
    output logic               run_q,
    output logic               run_nxt,
    output logic [N_CODEC-1:0] pres_q
);

    typedef struct packed {
        logic               run;
        logic [N_CODEC-1:0] pres;
    } gctl_st_t;

    gctl_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.pres = codec_present;
        if (wr_run) begin
            st_d.run = wr_run_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign run_q   = st_q.run;
    assign run_nxt = st_d.run;
    assign pres_q  = st_q.pres;

endmodule

// File: rtl/aud_imm_cmdpath.sv
module aud_imm_cmdpath
    import aud_imm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_nxt,
    input  logic              wr_cmd,
    input  logic              wr_sts,
    input  logic [REG_DW-1:0] wdata,
    input  logic              cdc_ack,
    input  logic              cdc_rsp_vld,
    input  logic [REG_DW-1:0] cdc_rsp_data,
    output logic              cdc_req,
    output logic [REG_DW-1:0] cmd_q,
    output logic [REG_DW-1:0] resp_q,
    output logic              busy_q,
    output logic              valid_q
);

    cmd_st_t st_d, st_q;
    logic    idle_q;

    assign idle_q = (st_q.phase == PH_IDLE);

    always_comb begin
        st_d = st_q;
        if (!run_nxt) begin
            st_d.cmd   = '0;
            st_d.resp  = '0;
            st_d.valid = 1'b0;
            st_d.phase = PH_IDLE;
        end else begin
            unique case (st_q.phase)
                PH_REQ: begin
                    if (cdc_ack) begin
                        st_d.phase = PH_WAIT;
                    end
                end
                PH_WAIT: begin
                    if (cdc_rsp_vld) begin
                        st_d.resp  = cdc_rsp_data;
                        st_d.valid = 1'b1;
                        st_d.phase = PH_IDLE;
                    end
                end
                default: ;
            endcase
            if (wr_cmd && idle_q) begin
                st_d.cmd = wdata;
            end
            if (wr_sts && idle_q) begin
                if (wdata[1]) begin
                    st_d.valid = 1'b0;
                end
                if (wdata[1:0] == 2'b11) begin
                    st_d.phase = PH_REQ;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cdc_req = (st_q.phase == PH_REQ);
    assign cmd_q   = st_q.cmd;
    assign resp_q  = st_q.resp;
    assign busy_q  = !idle_q;
    assign valid_q = st_q.valid;

endmodule

// File: rtl/aud_imm_rdmux.sv
module aud_imm_rdmux
    import aud_imm_pkg::*;
#(
    parameter int N_CODEC = 3
) (
    input  logic [REG_AW-1:0]  raddr,
    input  logic               run_q,
    input  logic [N_CODEC-1:0] pres_q,
    input  logic [REG_DW-1:0]  cmd_q,
    input  logic [REG_DW-1:0]  resp_q,
    input  logic               busy_q,
    input  logic               valid_q,
    output logic [REG_DW-1:0]  rdata
);

    logic [N_CODEC-1:0] pres_vis;
    logic [REG_DW-1:0]  pres_word;

    for (genvar gi = 0; gi < N_CODEC; gi++) begin : g_pres
        assign pres_vis[gi] = pres_q[gi] & run_q;
    end

    assign pres_word = REG_DW'(pres_vis) << PRES_LSB;

    always_comb begin
        rdata = '0;
        if (dw_hit(raddr, OFS_GCTL)) begin
            rdata[0] = run_q;
        end else if (dw_hit(raddr, OFS_PRES)) begin
            rdata = pres_word;
        end else if (dw_hit(raddr, OFS_CMD)) begin
            rdata = cmd_q;
        end else if (dw_hit(raddr, OFS_RSP)) begin
            rdata = resp_q;
        end else if (dw_hit(raddr, OFS_STS)) begin
            rdata[1:0] = {valid_q, busy_q};
        end
    end

endmodule

// File: rtl/aud_imm_cmd.sv
module aud_imm_cmd
    import aud_imm_pkg::*;
#(
    parameter int N_CODEC = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic [REG_AW-1:0]  reg_waddr,
    input  logic [REG_DW-1:0]  reg_wdata,
    input  logic [REG_AW-1:0]  reg_raddr,
    output logic [REG_DW-1:0]  reg_rdata,
    input  logic [N_CODEC-1:0] codec_present,
    output logic               cdc_req,
    output logic [REG_DW-1:0]  cdc_verb,
    input  logic               cdc_ack,
    input  logic               cdc_rsp_vld,
    input  logic [REG_DW-1:0]  cdc_rsp_data
);

    logic               wr_gctl, wr_cmd, wr_sts;
    logic               run_q, run_nxt;
    logic [N_CODEC-1:0] pres_q;
    logic [REG_DW-1:0]  cmd_q, resp_q;
    logic               busy_q, valid_q;

    assign wr_gctl = reg_wr && dw_hit(reg_waddr, OFS_GCTL);
    assign wr_cmd  = reg_wr && dw_hit(reg_waddr, OFS_CMD);
    assign wr_sts  = reg_wr && dw_hit(reg_waddr, OFS_STS);

    aud_imm_gctl #(.N_CODEC(N_CODEC)) u_gctl (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_run        (wr_gctl),
        .wr_run_val    (reg_wdata[0]),
        .codec_present (codec_present),
        .run_q         (run_q),
        .run_nxt       (run_nxt),
        .pres_q        (pres_q)
    );

    aud_imm_cmdpath u_cmdpath (
        .clk          (clk),
        .rst_n        (rst_n),
        .run_nxt      (run_nxt),
        .wr_cmd       (wr_cmd),
        .wr_sts       (wr_sts),
        .wdata        (reg_wdata),
        .cdc_ack      (cdc_ack),
        .cdc_rsp_vld  (cdc_rsp_vld),
        .cdc_rsp_data (cdc_rsp_data),
        .cdc_req      (cdc_req),
        .cmd_q        (cmd_q),
        .resp_q       (resp_q),
        .busy_q       (busy_q),
        .valid_q      (valid_q)
    );

    aud_imm_rdmux #(.N_CODEC(N_CODEC)) u_rdmux (
        .raddr   (reg_raddr),
        .run_q   (run_q),
        .pres_q  (pres_q),
        .cmd_q   (cmd_q),
        .resp_q  (resp_q),
        .busy_q  (busy_q),
        .valid_q (valid_q),
        .rdata   (reg_rdata)
    );

    assign cdc_verb = cmd_q;

endmodule

// File: rtl/aud_imm_cmd_chk.sv
module aud_imm_cmd_chk
    import aud_imm_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [REG_AW-1:0] reg_waddr,
    input logic [1:0]        wlow,
    input logic              cdc_req,
    input logic [REG_DW-1:0] cdc_verb,
    input logic              cdc_ack,
    input logic              cdc_rsp_vld,
    input logic              run_q,
    input logic              busy_q,
    input logic              valid_q
);

    logic halt_w, launch_w;
    assign halt_w   = reg_wr && dw_hit(reg_waddr, OFS_GCTL) && !wlow[0];
    assign launch_w = reg_wr && dw_hit(reg_waddr, OFS_STS) && (wlow == 2'b11);

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        cdc_req && !cdc_ack && !halt_w |=> cdc_req); // R6

    AST_VERB_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q && !halt_w |=> $stable(cdc_verb)); // R9

    AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !run_q |-> !cdc_req && !busy_q && !valid_q); // R3

    AST_STATUS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_q && valid_q)); // R7

    AST_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
        run_q && !busy_q && launch_w && !halt_w |=> cdc_req && busy_q && !valid_q); // R5

    AST_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q && !cdc_req && cdc_rsp_vld && !halt_w |=> valid_q && !busy_q); // R7

    AST_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        halt_w |=> !cdc_req && !busy_q && !valid_q); // R10

endmodule

bind aud_imm_cmd aud_imm_cmd_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr      (reg_wr),
    .reg_waddr   (reg_waddr),
    .wlow        (reg_wdata[1:0]),
    .cdc_req     (cdc_req),
    .cdc_verb    (cdc_verb),
    .cdc_ack     (cdc_ack),
    .cdc_rsp_vld (cdc_rsp_vld),
    .run_q       (run_q),
    .busy_q      (busy_q),
    .valid_q     (valid_q)
);

// File: tb/aud_imm_cmd_test.sv
module aud_imm_cmd_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_waddr = '0;
    logic [31:0] reg_wdata = '0;
    logic [7:0]  reg_raddr = '0;
    logic [31:0] reg_rdata;
    logic [2:0]  codec_present = '0;
    logic        cdc_req;
    logic [31:0] cdc_verb;
    logic        cdc_ack = 1'b0;
    logic        cdc_rsp_vld = 1'b0;
    logic [31:0] cdc_rsp_data = '0;

    always #10 clk = ~clk;

    aud_imm_cmd #(.N_CODEC(3)) uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_waddr(reg_waddr),
        .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
        .codec_present(codec_present), .cdc_req(cdc_req), .cdc_verb(cdc_verb),
        .cdc_ack(cdc_ack), .cdc_rsp_vld(cdc_rsp_vld), .cdc_rsp_data(cdc_rsp_data)
    );

    // behavioural reference: 0 idle, 1 offering verb, 2 awaiting response
    int          m_phase = 0;
    bit          m_run = 0, m_valid = 0;
    bit   [2:0]  m_pres = 0;
    bit   [31:0] m_cmd = 0, m_resp = 0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_phase = 0; m_run = 0; m_valid = 0; m_pres = 0; m_cmd = 0; m_resp = 0;
        end else begin
            int  old_ph;
            bit  next_run;
            int  dw;
            old_ph   = m_phase;
            dw       = int'(reg_waddr >> 2);
            next_run = (reg_wr && dw == 2) ? reg_wdata[0] : m_run;
            m_pres   = codec_present;
            m_run    = next_run;
            if (!next_run) begin
                m_phase = 0; m_valid = 0; m_cmd = 0; m_resp = 0;
            end else begin
                if (old_ph == 1 && cdc_ack) m_phase = 2;
                if (old_ph == 2 && cdc_rsp_vld) begin
                    m_resp = cdc_rsp_data; m_valid = 1; m_phase = 0;
                end
                if (reg_wr && old_ph == 0 && dw == 24) m_cmd = reg_wdata;
                if (reg_wr && old_ph == 0 && dw == 26) begin
                    if (reg_wdata[1]) m_valid = 0;
                    if (reg_wdata[1:0] == 2'b11) m_phase = 1;
                end
            end
        end
    end

    int vectors = 0, miscompares = 0, cycles = 0, rot = 0;
    bit done = 0;

    function automatic logic [31:0] exp_read(input logic [7:0] a);
        case (int'(a >> 2))
            2:  return {31'b0, m_run};
            3:  return m_run ? (32'(m_pres) << 16) : 32'h0;
            24: return m_cmd;
            25: return m_resp;
            26: return {30'b0, m_valid, m_phase != 0};
            default: return 32'h0;
        endcase
    endfunction

    function automatic string tag_of(input logic [7:0] a);
        case (int'(a >> 2))
            2:  return "R3";
            3:  return "R4";
            24: return "R9";
            25: return "R7";
            26: return "R5";
            default: return "R2";
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        vectors++;
        if (got !== exp) begin
            miscompares++;
            $display("FAIL %s t=%0t got=%h expected=%h", tag, $time, got, exp);
        end
    endtask

    task automatic compare_all();
        check("R6 cdc_req", {31'b0, cdc_req}, {31'b0, m_phase == 1});
        check("R5 cdc_verb", cdc_verb, m_cmd);
        check(tag_of(reg_raddr), reg_rdata, exp_read(reg_raddr));
    endtask

    task automatic step(input logic w, input logic [7:0] a, input logic [31:0] d,
                        input logic ak, input logic rv, input logic [31:0] rd);
        logic [7:0] rlist [6];
        rlist = '{8'h08, 8'h0E, 8'h60, 8'h64, 8'h68, 8'h40};
        @(negedge clk);
        compare_all();
        reg_wr = w; reg_waddr = a; reg_wdata = d;
        cdc_ack = ak; cdc_rsp_vld = rv; cdc_rsp_data = rd;
        reg_raddr = rlist[rot % 6];
        rot++;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 8'h00, 32'h0, 0, 0, 32'h0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 200000 && !done) begin
            miscompares++;
            $display("FAIL watchdog expired got=hung expected=finished");
            finish_run();
        end
    end

    initial begin
        // R1: reset values on every offset, including unmapped 40h (R2)
        idle(3);
        @(negedge clk); rst_n = 1'b1;
        idle(8);
        // R3: writes while halted are ignored; R4: presence hidden while halted
        codec_present = 3'b101;
        step(1, 8'h60, 32'h1234_5678, 0, 0, 0);
        step(1, 8'h68, 32'h3, 0, 0, 0);
        idle(7);
        // R3/R4: run, then presence appears (byte 0Eh read)
        step(1, 8'h08, 32'h1, 0, 0, 0);
        idle(6);
        codec_present = 3'b011;
        idle(6);
        // R5: 01b and 10b do not launch; 11b launches
        step(1, 8'h60, 32'h200F_0000, 0, 0, 0);
        step(1, 8'h68, 32'h1, 0, 0, 0);
        idle(2);
        step(1, 8'h68, 32'h2, 0, 0, 0);
        idle(2);
        step(1, 8'h68, 32'h3, 0, 0, 0);
        // R6: request held without acknowledge; R7: early strobe ignored
        idle(3);
        step(0, 8'h00, 32'h0, 0, 1, 32'hBAD0_BAD0);
        step(0, 8'h00, 32'h0, 1, 0, 0);
        idle(2);
        // R9: command and status writes while busy are ignored
        step(1, 8'h60, 32'hDEAD_BEEF, 0, 0, 0);
        step(1, 8'h68, 32'h3, 0, 0, 0);
        idle(6);
        // R7: response captured, status 10b
        step(0, 8'h00, 32'h0, 0, 1, 32'hCAFE_F00D);
        idle(7);
        // R8: clear response-valid, response kept
        step(1, 8'h68, 32'h2, 0, 0, 0);
        idle(6);
        // R7: strobe in the acknowledge cycle ignored, later one captured
        step(1, 8'h60, 32'h100F_0001, 0, 0, 0);
        step(1, 8'h68, 32'h3, 0, 0, 0);
        step(0, 8'h00, 32'h0, 1, 1, 32'h0000_0011);
        idle(2);
        step(0, 8'h00, 32'h0, 0, 1, 32'h0000_0022);
        idle(6);
        // R5: relaunch with valid still set clears it; R10: abort while waiting
        step(1, 8'h68, 32'h3, 0, 0, 0);
        step(0, 8'h00, 32'h0, 1, 0, 0);
        idle(2);
        step(1, 8'h08, 32'h0, 0, 0, 0);
        step(0, 8'h00, 32'h0, 0, 1, 32'h5555_AAAA);
        idle(7);
        // R10: run again, everything still cleared
        step(1, 8'h08, 32'h1, 0, 0, 0);
        idle(7);
        @(negedge clk);
        compare_all();
        finish_run();
    end

endmodule